// File: doc/BRIEF.md
# Dual-Clock Up/Down Cascadable Counter

This block is a binary counter, four bits wide by default, with no direction bit. It has two count strobes instead. A rising edge on the increment strobe moves the count up by one, and a rising edge on the decrement strobe moves it down by one. In either case the opposite strobe must rest high. An active-low preset input copies a parallel data word into the count. An active-high clear forces the count to zero and outranks every other input.

Two active-low outputs let identical stages be chained with no glue logic. The up-overflow output is low while the count sits at its maximum and the increment strobe is low. The down-underflow output is low while the count sits at zero and the decrement strobe is low. Each of these pulses is therefore as wide as the strobe that produces it. Its trailing rising edge is the edge the next stage counts: wire up-overflow to the next stage's increment strobe and down-underflow to its decrement strobe.

Every control and data input passes through a two-flop synchronizer into the system clock domain. Strobe edges are detected on the synchronized levels, and all count bits update together on one clock edge. A counter that presets itself whenever it reaches a terminal value divides its strobe rate by a chosen modulus.

Top module: `dual_clock_counter`

## Requirements
- R1: A rising edge on `inc_strobe` while `dec_strobe` is high adds one to `count_q`. The count wraps from 15 to 0.
- R2: A rising edge on `dec_strobe` while `inc_strobe` is high subtracts one from `count_q`. The count wraps from 0 to 15.
- R3: While `preset_n` is low, `count_q` follows `preset_val`, and strobe edges have no effect.
- R4: While `wipe` is high, `count_q` is 0, whatever the state of `preset_n`, `preset_val` and both strobes.
- R5: A strobe edge that arrives while the other strobe is low leaves the count unchanged. Rising edges on both strobes in the same cycle also leave the count unchanged.
- R6: `ovf_n` is low exactly while the count is 15 and the synchronized `inc_strobe` is low. The number of cycles it stays low equals the number of cycles the strobe was held low.
- R7: `unf_n` is low exactly while the count is 0 and the synchronized `dec_strobe` is low. The number of cycles it stays low equals the number of cycles the strobe was held low.
- R8: Two stages chained through `ovf_n`→`inc_strobe` and `unf_n`→`dec_strobe` form an 8-bit up/down counter.
- R9: A change at an input pin reaches `count_q` on the third rising clock edge after the change: two synchronizer edges, then the state edge.
- R10: After synchronous reset, `count_q` is 0 and both `ovf_n` and `unf_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| inc_strobe | input | 1 | Count-up strobe, counts on rising edge |
| dec_strobe | input | 1 | Count-down strobe, counts on rising edge |
| wipe | input | 1 | Active-high clear, highest priority |
| preset_n | input | 1 | Active-low parallel preset enable |
| preset_val | input | 4 | Preset data word |
| count_q | output | 4 | Current count |
| ovf_n | output | 1 | Active-low overflow pulse for cascading |
| unf_n | output | 1 | Active-low underflow pulse for cascading |

## Verification
Clear and preset can both be active while strobe edges arrive, so three functions meet in one cycle. The bench holds `wipe` and `preset_n` active together and pulses a strobe, then expects zero. It also holds only the preset active during a strobe pulse and expects the preset word. A second pair collides when both strobes rise in the same cycle, and the bench expects the count to hold. The cascade test judges the overflow and underflow pulse widths, and the upper stage's count, against values computed in the bench.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

    typedef enum logic [2:0] {
        STEP_HOLD,
        STEP_CLEAR,
        STEP_LOAD,
        STEP_INC,
        STEP_DEC
    } step_e;

    typedef struct packed {
        logic clr;
        logic load_n;
        logic up;
        logic dn;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{clr: 1'b0, load_n: 1'b1, up: 1'b1, dn: 1'b1};
    localparam int   CTL_W    = $bits(ctl_t);

    // Priority: clear, then preset, then a single qualified strobe edge.
    function automatic step_e pick_step(ctl_t lvl, logic up_rise, logic dn_rise);
        step_e s;
        if (lvl.clr)                 s = STEP_CLEAR;
        else if (!lvl.load_n)        s = STEP_LOAD;
        else if (up_rise && dn_rise) s = STEP_HOLD;
        else if (up_rise && lvl.dn)  s = STEP_INC;
        else if (dn_rise && lvl.up)  s = STEP_DEC;
        else                         s = STEP_HOLD;
        return s;
    endfunction

endpackage

// File: rtl/dcc_sync.sv
module dcc_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/dcc_steer.sv
module dcc_steer
    import dcc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctl_t  lvl,
    output step_e step
);
    logic up_prev, dn_prev;
    logic up_rise, dn_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            up_prev <= 1'b1;
            dn_prev <= 1'b1;
        end else begin
            up_prev <= lvl.up;
            dn_prev <= lvl.dn;
        end
    end

    assign up_rise = lvl.up && !up_prev;
    assign dn_rise = lvl.dn && !dn_prev;

    always_comb step = pick_step(lvl, up_rise, dn_rise);

    // R5: an up edge while the down strobe is low must not count up
    p_gated_up_r5: assert property (@(posedge clk) disable iff (rst)
        (up_rise && !lvl.dn) |-> (step != STEP_INC));

    // R5: a down edge while the up strobe is low must not count down
    p_gated_dn_r5: assert property (@(posedge clk) disable iff (rst)
        (dn_rise && !lvl.up) |-> (step != STEP_DEC));
endmodule

// File: rtl/dcc_core.sv
module dcc_core
    import dcc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  step_e            step,
    input  logic [WIDTH-1:0] data,
    input  logic             up_lvl,
    input  logic             dn_lvl,
    output logic [WIDTH-1:0] count,
    output logic             carry_n,
    output logic             borrow_n
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] nxt;

    always_comb begin
        unique case (step)
            STEP_CLEAR: nxt = '0;
            STEP_LOAD:  nxt = data;
            STEP_INC:   nxt = count + ONE;
            STEP_DEC:   nxt = count - ONE;
            default:    nxt = count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= nxt;
    end

    assign carry_n  = !((count == TOP) && !up_lvl);
    assign borrow_n = !((count == '0)  && !dn_lvl);

    p_inc_r1: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_INC) |=> (count == $past(count) + ONE));

    p_dec_r2: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_DEC) |=> (count == $past(count) - ONE));

    p_load_r3: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_LOAD) |=> (count == $past(data)));

    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_CLEAR) |=> (count == '0));

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_HOLD) |=> $stable(count));

    p_carry_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(carry_n) |-> (count == TOP));

    p_borrow_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(borrow_n) |-> (count == '0));
endmodule

// File: rtl/dual_clock_counter.sv
module dual_clock_counter
    import dcc_pkg::*;
#(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_strobe,
    input  logic             dec_strobe,
    input  logic             wipe,
    input  logic             preset_n,
    input  logic [WIDTH-1:0] preset_val,
    output logic [WIDTH-1:0] count_q,
    output logic             ovf_n,
    output logic             unf_n
);
    ctl_t             ctl_raw, ctl_lvl;
    logic [CTL_W-1:0] ctl_vec;
    logic [WIDTH-1:0] data_lvl;
    step_e            step;

    assign ctl_raw = '{clr: wipe, load_n: preset_n, up: inc_strobe, dn: dec_strobe};

    dcc_sync #(.W(CTL_W), .STAGES(STAGES), .RST_VAL(CTL_IDLE)) u_ctl_sync (
        .clk(clk), .rst(rst), .d(ctl_raw), .q(ctl_vec)
    );

    dcc_sync #(.W(WIDTH), .STAGES(STAGES), .RST_VAL('0)) u_data_sync (
        .clk(clk), .rst(rst), .d(preset_val), .q(data_lvl)
    );

    assign ctl_lvl = ctl_t'(ctl_vec);

    dcc_steer u_steer (
        .clk(clk), .rst(rst), .lvl(ctl_lvl), .step(step)
    );

    dcc_core #(.WIDTH(WIDTH)) u_core (
        .clk(clk), .rst(rst), .step(step), .data(data_lvl),
        .up_lvl(ctl_lvl.up), .dn_lvl(ctl_lvl.dn),
        .count(count_q), .carry_n(ovf_n), .borrow_n(unf_n)
    );
endmodule

// File: tb/test_dual_clock_counter.sv
module test_dual_clock_counter;
    logic       clk = 1'b0;
    logic       rst;
    logic       up, dn, clr, ld_n;
    logic [3:0] din;
    logic [3:0] q, hi_q;
    logic       carry_n, borrow_n, hi_c, hi_b;
    int         checks = 0;
    int         errors = 0;

    always #10 clk = ~clk;

    dual_clock_counter i_dual_clock_counter (
        .clk(clk), .rst(rst), .inc_strobe(up), .dec_strobe(dn), .wipe(clr),
        .preset_n(ld_n), .preset_val(din), .count_q(q), .ovf_n(carry_n), .unf_n(borrow_n)
    );

    // Upper stage of a two-stage chain
    dual_clock_counter i_dual_clock_counter_hi (
        .clk(clk), .rst(rst), .inc_strobe(carry_n), .dec_strobe(borrow_n), .wipe(clr),
        .preset_n(1'b1), .preset_val(4'd0), .count_q(hi_q), .ovf_n(hi_c), .unf_n(hi_b)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic pulse_up();
        @(negedge clk) up = 1'b0;
        repeat (4) @(negedge clk);
        up = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_dn();
        @(negedge clk) dn = 1'b0;
        repeat (4) @(negedge clk);
        dn = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_clear();
        @(negedge clk) clr = 1'b1;
        settle();
        clr = 1'b0;
        settle();
    endtask

    task automatic do_load(logic [3:0] v);
        @(negedge clk) begin ld_n = 1'b0; din = v; end
        settle();
        ld_n = 1'b1;
        settle();
    endtask

    task automatic t_reset_r10();
        rst = 1'b1; up = 1'b1; dn = 1'b1; clr = 1'b0; ld_n = 1'b1; din = 4'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 count", q, 0);
        chk("R10 ovf_n", carry_n, 1);
        chk("R10 unf_n", borrow_n, 1);
    endtask

    task automatic t_latency_r9();
        do_load(4'd3);
        @(negedge clk) up = 1'b0;
        repeat (3) @(negedge clk);
        up = 1'b1;
        @(negedge clk) chk("R9 after 1 edge", q, 3);
        @(negedge clk) chk("R9 after 2 edges", q, 3);
        @(negedge clk) chk("R9 after 3 edges", q, 4);
        settle();
    endtask

    task automatic t_up_wrap_r1();
        do_load(4'd14);
        pulse_up();
        chk("R1 14+1", q, 15);
        pulse_up();
        chk("R1 wrap 15->0", q, 0);
    endtask

    task automatic t_dn_wrap_r2();
        do_load(4'd1);
        pulse_dn();
        chk("R2 1-1", q, 0);
        pulse_dn();
        chk("R2 wrap 0->15", q, 15);
    endtask

    task automatic t_load_r3();
        @(negedge clk) begin ld_n = 1'b0; din = 4'd9; end
        settle();
        pulse_up();
        pulse_dn();
        chk("R3 preset holds against strobes", q, 9);
        din = 4'd6;
        settle();
        chk("R3 count follows data while preset low", q, 6);
        ld_n = 1'b1;
        settle();
        chk("R3 value kept after release", q, 6);
    endtask

    task automatic t_clear_r4();
        do_load(4'd11);
        @(negedge clk) begin clr = 1'b1; ld_n = 1'b0; din = 4'd5; end
        pulse_up();
        chk("R4 clear beats preset and strobe", q, 0);
        ld_n = 1'b1;
        settle();
        chk("R4 clear still wins after preset release", q, 0);
        clr = 1'b0;
        settle();
    endtask

    task automatic t_gating_r5();
        do_load(4'd7);
        @(negedge clk) dn = 1'b0;
        settle();
        pulse_up();
        chk("R5 up edge blocked by low down strobe", q, 7);
        dn = 1'b1;
        settle();
        chk("R2 down strobe release counts down", q, 6);
        @(negedge clk) begin up = 1'b0; dn = 1'b0; end
        settle();
        up = 1'b1; dn = 1'b1;
        settle();
        chk("R5 simultaneous rises hold", q, 6);
    endtask

    task automatic t_carry_r6();
        int low = 0;
        do_load(4'd15);
        @(negedge clk) up = 1'b0;
        for (int i = 1; i <= 16; i++) begin
            @(negedge clk);
            if (!carry_n) low++;
            if (i == 5) up = 1'b1;
        end
        chk("R6 ovf_n low width", low, 5);
        chk("R6 count after overflow", q, 0);
        chk("R6 ovf_n released", carry_n, 1);
    endtask

    task automatic t_borrow_r7();
        int low = 0;
        do_load(4'd0);
        @(negedge clk) dn = 1'b0;
        for (int i = 1; i <= 16; i++) begin
            @(negedge clk);
            if (!borrow_n) low++;
            if (i == 7) dn = 1'b1;
        end
        chk("R7 unf_n low width", low, 7);
        chk("R7 count after underflow", q, 15);
        chk("R7 unf_n released", borrow_n, 1);
    endtask

    task automatic t_cascade_r8();
        do_clear();
        chk("R8 cleared low", q, 0);
        chk("R8 cleared high", hi_q, 0);
        for (int i = 0; i < 16; i++) pulse_up();
        settle();
        chk("R8 low stage after 16 ups", q, 0);
        chk("R8 high stage after 16 ups", hi_q, 1);
        for (int i = 0; i < 3; i++) pulse_up();
        settle();
        chk("R8 combined 19", {hi_q, q}, 19);
        for (int i = 0; i < 4; i++) pulse_dn();
        settle();
        chk("R8 low stage after borrow", q, 15);
        chk("R8 high stage after borrow", hi_q, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset_r10();
        t_latency_r9();
        t_up_wrap_r1();
        t_dn_wrap_r2();
        t_load_r3();
        t_clear_r4();
        t_gating_r5();
        t_carry_r6();
        t_borrow_r7();
        t_cascade_r8();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule